// File: doc/BRIEF.md
# Cipher Configuration and Key Register Bank

This block is the register front end for a block-cipher engine. Software writes a control word that turns the engine on or off, picks encryption or decryption, sets the key length, the chaining mode and the segment width used by the feedback mode. It also loads up to eight 32-bit key words. The block turns all of this into decoded configuration and a flat key vector for the cipher datapath next to it.

A key word can be overwritten or combined with its stored value by XOR. This lets a key be built from several shares without any share ever being visible on its own. Configuration and keys are locked while the engine is enabled. A single self-clearing reset bit returns every register to its power-up value. A second control word raises a one-cycle pulse that tells the datapath the next block starts a new message.

The bus is word-addressed. Writes are synchronous. Read data is a combinational function of the address.

Top module: `cipher_cfg_regs`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, every output is zero. A zero key size means 128 bits, and a zero segment code means 8 bits.
- R2: Bit 1 of the control word at address 0 is the enable. A write to address 0 with bit 0 clear loads the enable from bit 1 at the next edge, whatever the current state.
- R3: The other fields of address 0 are the encrypt bit (bit 2), the key size (bits 4:3), the mode (bits 7:5), the segment code (bits 10:8) and the XOR-key bit (bit 11). They are loaded only if the enable was 0 before the write. While enabled, writes to these fields are dropped.
- R4: Key size codes are 0=128, 1=192 and 2=256 bits. Segment codes are 0=8, 1=16, 2=32, 3=64 and 4=128 bits. A write carrying key size 3 or a segment code of 5 to 7 leaves that field unchanged, while the other fields of the same write still apply.
- R5: Addresses 8 to 15 hold key words 0 to 7. With the XOR-key bit clear, a write stores the data as given. Word i drives bits 32i+31 to 32i of `key_o`.
- R6: With the XOR-key bit set, a key write stores the XOR of the written data and the old word.
- R7: Key writes are dropped while the enable is 1.
- R8: On `key_o`, words at index 4 or above read as zero for a 128-bit key, and words at index 6 or above read as zero for a 192-bit key.
- R9: A write to address 0 with bit 0 set changes nothing but the reset bit, which reads back as 1 for exactly one cycle. At the edge ending that cycle, all fields and all key words return to zero and the bit clears.
- R10: Any write presented during the cycle in which the reset bit reads 1 is ignored.
- R11: A write to address 1 with bit 0 set makes `new_msg_o` high for the following cycle only. Address 1 reads as zero.
- R12: Address 0 reads back the current fields at the bit positions above, with the reset bit at bit 0. Key words and all other addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| enable_o | output | 1 | Engine enabled |
| encrypt_o | output | 1 | 1 for encryption, 0 for decryption |
| key_size_o | output | 2 | Key size code |
| mode_o | output | 3 | Chaining mode code |
| seg_size_o | output | 3 | Feedback segment code |
| new_msg_o | output | 1 | One-cycle new-message pulse |
| key_o | output | 256 | Key, masked to the selected size |

## Verification
Some behaviours are checked by the checker on every cycle:
- the lock on configuration and key while enabled;
- the one-cycle life of the reset bit and the all-zero state that follows it;
- that the enable follows each control write;
- that illegal size codes never appear on the outputs;
- that the new-message pulse always traces back to a write;
- that key words above the 128-bit limit are masked.

Other behaviours can only be shown by the bench's scenarios, because they depend on the values written:
- the exact register values seen through readback;
- the XOR accumulation of key shares;
- partial masking for the 192-bit size;
- that an illegal code leaves the old field in place while the rest of the write applies;
- that a write in the reset cycle leaves no trace.

// File: rtl/cipher_cfg_pkg.sv
package cipher_cfg_pkg;

  localparam int KS_W   = 2;
  localparam int MODE_W = 3;
  localparam int SEG_W  = 3;

  // control word bit positions
  localparam int F_SWRST = 0;
  localparam int F_EN    = 1;
  localparam int F_ENC   = 2;
  localparam int F_KS    = 3;
  localparam int F_MODE  = F_KS + KS_W;
  localparam int F_SEG   = F_MODE + MODE_W;
  localparam int F_XOR   = F_SEG + SEG_W;
  localparam int CTRL_W  = F_XOR + 1;

  localparam int KS_CODES  = 3;
  localparam int SEG_CODES = 5;

  localparam int CTRL_A_ADDR = 0;
  localparam int CTRL_B_ADDR = 1;

  typedef enum logic [KS_W-1:0] {
    KS_128 = 2'd0,
    KS_192 = 2'd1,
    KS_256 = 2'd2
  } key_size_e;

  // packed so that its bit order matches the control word from F_ENC upward
  typedef struct packed {
    logic              xor_key;
    logic [SEG_W-1:0]  seg;
    logic [MODE_W-1:0] mode;
    logic [KS_W-1:0]   ks;
    logic              enc;
  } cfg_t;

  function automatic int words_for(logic [KS_W-1:0] ks);
    case (key_size_e'(ks))
      KS_192:  return 6;
      KS_256:  return 8;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int ADDR_W        = 4,
  parameter int NUM_KEY_WORDS = 8,
  localparam int KIDX_W       = $clog2(NUM_KEY_WORDS)
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  output logic                     wr_a_o,
  output logic                     wr_b_o,
  output logic [NUM_KEY_WORDS-1:0] key_we_o
);
  import cipher_cfg_pkg::*;

  logic key_hit;

  assign wr_a_o  = we_i && (addr_i == ADDR_W'(CTRL_A_ADDR));
  assign wr_b_o  = we_i && (addr_i == ADDR_W'(CTRL_B_ADDR));
  assign key_hit = we_i && ((addr_i >> KIDX_W) == ADDR_W'(1));

  for (genvar g = 0; g < NUM_KEY_WORDS; g++) begin : g_kwe
    assign key_we_o[g] = key_hit && (addr_i[KIDX_W-1:0] == KIDX_W'(g));
  end

endmodule

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_a_i,
  input  logic                              wr_b_i,
  input  logic [cipher_cfg_pkg::CTRL_W-1:0] wdata_i,
  output cipher_cfg_pkg::cfg_t              cfg_o,
  output logic                              enable_o,
  output logic                              swrst_o,
  output logic                              new_msg_o
);
  import cipher_cfg_pkg::*;

  cfg_t cfg_q;
  logic enable_q, swrst_q, new_msg_q;
  cfg_t wcfg;

  assign wcfg = cfg_t'(wdata_i[CTRL_W-1:F_ENC]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      enable_q  <= 1'b0;
      swrst_q   <= 1'b0;
      new_msg_q <= 1'b0;
    end else if (swrst_q) begin
      // reset cycle: clear everything, ignore the bus
      cfg_q     <= '0;
      enable_q  <= 1'b0;
      swrst_q   <= 1'b0;
      new_msg_q <= 1'b0;
    end else begin
      new_msg_q <= wr_b_i && wdata_i[0];
      if (wr_a_i) begin
        if (wdata_i[F_SWRST]) begin
          swrst_q <= 1'b1;
        end else begin
          enable_q <= wdata_i[F_EN];
          if (!enable_q) begin
            cfg_q.enc     <= wcfg.enc;
            cfg_q.mode    <= wcfg.mode;
            cfg_q.xor_key <= wcfg.xor_key;
            if (int'(wcfg.ks) < KS_CODES)   cfg_q.ks  <= wcfg.ks;
            if (int'(wcfg.seg) < SEG_CODES) cfg_q.seg <= wcfg.seg;
          end
        end
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign enable_o  = enable_q;
  assign swrst_o   = swrst_q;
  assign new_msg_o = new_msg_q;

endmodule

// File: rtl/cfg_key_bank.sv
module cfg_key_bank #(
  parameter int NUM_KEY_WORDS = 8,
  parameter int WORD_W        = 32,
  localparam int KEY_W        = NUM_KEY_WORDS * WORD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_KEY_WORDS-1:0] we_i,
  input  logic [WORD_W-1:0]        wdata_i,
  input  logic                     xor_i,
  input  logic                     lock_i,
  input  logic                     clr_i,
  output logic [KEY_W-1:0]         key_o
);

  for (genvar g = 0; g < NUM_KEY_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                word_q <= '0;
      else if (clr_i)             word_q <= '0;
      else if (we_i[g] && !lock_i) word_q <= xor_i ? (word_q ^ wdata_i) : wdata_i;
    end

    assign key_o[g*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/cfg_key_mask.sv
module cfg_key_mask #(
  parameter int NUM_KEY_WORDS = 8,
  parameter int WORD_W        = 32,
  localparam int KEY_W        = NUM_KEY_WORDS * WORD_W
) (
  input  logic [KEY_W-1:0]                  key_i,
  input  logic [cipher_cfg_pkg::KS_W-1:0]   ks_i,
  output logic [KEY_W-1:0]                  key_o
);
  import cipher_cfg_pkg::*;

  int active;
  assign active = words_for(ks_i);

  for (genvar g = 0; g < NUM_KEY_WORDS; g++) begin : g_mask
    assign key_o[g*WORD_W +: WORD_W] = (g < active) ? key_i[g*WORD_W +: WORD_W] : '0;
  end

endmodule

// File: rtl/cipher_cfg_regs.sv
module cipher_cfg_regs #(
  parameter int ADDR_W        = 4,
  parameter int WORD_W        = 32,
  parameter int NUM_KEY_WORDS = 8,
  localparam int KEY_W        = NUM_KEY_WORDS * WORD_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic                              we_i,
  input  logic [WORD_W-1:0]                 wdata_i,
  output logic [WORD_W-1:0]                 rdata_o,
  output logic                              enable_o,
  output logic                              encrypt_o,
  output logic [cipher_cfg_pkg::KS_W-1:0]   key_size_o,
  output logic [cipher_cfg_pkg::MODE_W-1:0] mode_o,
  output logic [cipher_cfg_pkg::SEG_W-1:0]  seg_size_o,
  output logic                              new_msg_o,
  output logic [KEY_W-1:0]                  key_o
);
  import cipher_cfg_pkg::*;

  logic                     wr_a, wr_b;
  logic [NUM_KEY_WORDS-1:0] key_we;
  cfg_t                     cfg;
  logic                     enable, swrst_act;
  logic [KEY_W-1:0]         key_raw;
  logic [CTRL_W-1:0]        ctrl_rd;

  cfg_addr_dec #(
    .ADDR_W       (ADDR_W),
    .NUM_KEY_WORDS(NUM_KEY_WORDS)
  ) u_dec (
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wr_a_o  (wr_a),
    .wr_b_o  (wr_b),
    .key_we_o(key_we)
  );

  cfg_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_a_i   (wr_a),
    .wr_b_i   (wr_b),
    .wdata_i  (wdata_i[CTRL_W-1:0]),
    .cfg_o    (cfg),
    .enable_o (enable),
    .swrst_o  (swrst_act),
    .new_msg_o(new_msg_o)
  );

  cfg_key_bank #(
    .NUM_KEY_WORDS(NUM_KEY_WORDS),
    .WORD_W       (WORD_W)
  ) u_keys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (key_we),
    .wdata_i(wdata_i),
    .xor_i  (cfg.xor_key),
    .lock_i (enable),
    .clr_i  (swrst_act),
    .key_o  (key_raw)
  );

  cfg_key_mask #(
    .NUM_KEY_WORDS(NUM_KEY_WORDS),
    .WORD_W       (WORD_W)
  ) u_mask (
    .key_i(key_raw),
    .ks_i (cfg.ks),
    .key_o(key_o)
  );

  assign ctrl_rd = {cfg, enable, swrst_act};
  assign rdata_o = (addr_i == ADDR_W'(CTRL_A_ADDR)) ? {{(WORD_W-CTRL_W){1'b0}}, ctrl_rd} : '0;

  assign enable_o   = enable;
  assign encrypt_o  = cfg.enc;
  assign key_size_o = cfg.ks;
  assign mode_o     = cfg.mode;
  assign seg_size_o = cfg.seg;

endmodule

// File: rtl/cipher_cfg_regs_chk.sv
module cipher_cfg_regs_chk #(
  parameter int ADDR_W        = 4,
  parameter int WORD_W        = 32,
  parameter int NUM_KEY_WORDS = 8,
  localparam int KEY_W        = NUM_KEY_WORDS * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [1:0]        wlow_i,
  input logic              swrst_act,
  input logic              enable_o,
  input logic              encrypt_o,
  input logic [1:0]        key_size_o,
  input logic [2:0]        mode_o,
  input logic [2:0]        seg_size_o,
  input logic              new_msg_o,
  input logic [KEY_W-1:0]  key_o
);
  import cipher_cfg_pkg::*;

  logic wr_a, wr_b;
  assign wr_a = we_i && (addr_i == ADDR_W'(CTRL_A_ADDR));
  assign wr_b = we_i && (addr_i == ADDR_W'(CTRL_B_ADDR));

  p_enable_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_a && !wlow_i[0] && !swrst_act) |=> (enable_o == $past(wlow_i[1])));

  p_cfg_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && !swrst_act) |=> ($stable(encrypt_o) && $stable(key_size_o)
                                  && $stable(mode_o) && $stable(seg_size_o)));

  p_legal_codes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_size_o != 2'd3) && (int'(seg_size_o) < SEG_CODES));

  p_key_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_o && !swrst_act) |=> $stable(key_o));

  p_mask_128_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_size_o == 2'd0) |-> (key_o[KEY_W-1:4*WORD_W] == '0));

  p_swrst_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_act |=> !swrst_act);

  p_swrst_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swrst_act) |-> $past(wr_a && wlow_i[0]));

  p_swrst_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_act |=> (!enable_o && !encrypt_o && key_size_o == '0 && mode_o == '0
                   && seg_size_o == '0 && key_o == '0 && !new_msg_o));

  p_newmsg_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_msg_o |-> $past(wr_b && wlow_i[0] && !swrst_act));

endmodule

bind cipher_cfg_regs cipher_cfg_regs_chk #(
  .ADDR_W       (ADDR_W),
  .WORD_W       (WORD_W),
  .NUM_KEY_WORDS(NUM_KEY_WORDS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wlow_i    (wdata_i[1:0]),
  .swrst_act (swrst_act),
  .enable_o  (enable_o),
  .encrypt_o (encrypt_o),
  .key_size_o(key_size_o),
  .mode_o    (mode_o),
  .seg_size_o(seg_size_o),
  .new_msg_o (new_msg_o),
  .key_o     (key_o)
);

// File: tb/cipher_cfg_regs_bench.sv
module cipher_cfg_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int W   = 32;
  localparam int NKW = 8;
  localparam int KW  = NKW * W;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          enable, encrypt, new_msg;
  logic [1:0]    key_size;
  logic [2:0]    mode, seg_size;
  logic [KW-1:0] key;

  always #(CLK_PERIOD/2) clk = ~clk;

  cipher_cfg_regs u_cipher_cfg_regs (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .enable_o  (enable),
    .encrypt_o (encrypt),
    .key_size_o(key_size),
    .mode_o    (mode),
    .seg_size_o(seg_size),
    .new_msg_o (new_msg),
    .key_o     (key)
  );

  typedef enum {S_RD, S_EN, S_ENC, S_KS, S_MODE, S_SEG, S_NM, S_KEY} sel_e;
  typedef struct {
    string         req;
    sel_e          sel;
    logic [KW-1:0] exp;
  } item_t;

  item_t       sb_q[$];
  int          total = 0;
  int          bad = 0;
  bit          done = 0;
  logic [W-1:0] kw [NKW];

  function automatic logic [KW-1:0] actual(sel_e s);
    case (s)
      S_RD:    return KW'(rdata);
      S_EN:    return KW'(enable);
      S_ENC:   return KW'(encrypt);
      S_KS:    return KW'(key_size);
      S_MODE:  return KW'(mode);
      S_SEG:   return KW'(seg_size);
      S_NM:    return KW'(new_msg);
      default: return key;
    endcase
  endfunction

  // expected key from the model: words beyond the selected size are zero
  function automatic logic [KW-1:0] ekey(int ks);
    logic [KW-1:0] k = '0;
    for (int i = 0; i < NKW; i++)
      if (i < 4 + 2*ks) k[i*W +: W] = kw[i];
    return k;
  endfunction

  task automatic push(string r, sel_e s, logic [KW-1:0] e);
    item_t it;
    it.req = r; it.sel = s; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    addr = AW'(a); wdata = d; we = 1'b1;
  endtask

  task automatic rd(int a);
    addr = AW'(a); we = 1'b0;
  endtask

  task automatic next();
    @(negedge clk);
    we = 1'b0;
  endtask

  // monitor: items pushed before an edge describe the state just after it
  always @(posedge clk) begin
    item_t it;
    logic [KW-1:0] act;
    #(CLK_PERIOD/4);
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      act = actual(it.sel);
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s %s actual=%h expected=%h", it.req, it.sel.name(), act, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NKW; i++) kw[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    push("R1", S_RD, '0); push("R1", S_EN, '0); push("R1", S_KEY, '0);
    push("R1", S_NM, '0); push("R1", S_MODE, '0); push("R1", S_SEG, '0);
    next();

    // R3 configure while disabled: enc=1 ks=2 mode=3 seg=4
    wr(0, 32'h474);
    push("R3", S_ENC, 1); push("R3", S_KS, 2); push("R3", S_MODE, 3);
    push("R3", S_SEG, 4); push("R2", S_EN, 0); push("R12", S_RD, 32'h474);
    next();

    // R5 direct key loads, R12 key words read zero
    for (int i = 0; i < NKW; i++) begin
      wr(8 + i, 32'hA000_0000 | W'(i));
      kw[i] = 32'hA000_0000 | W'(i);
      push("R5", S_KEY, ekey(2)); push("R12", S_RD, '0);
      next();
    end

    // R4 illegal key size 3 and segment 7 keep old fields
    wr(0, 32'h77C);
    push("R4", S_KS, 2); push("R4", S_SEG, 4); push("R4", S_MODE, 3);
    push("R12", S_RD, 32'h474);
    next();

    // R8 masking for 192 and 128
    wr(0, 32'h46C);
    push("R4", S_KS, 1); push("R8", S_KEY, ekey(1));
    next();
    wr(0, 32'h464);
    push("R8", S_KEY, ekey(0));
    next();

    // R6 XOR accumulation
    wr(0, 32'hC74);
    push("R12", S_RD, 32'hC74);
    next();
    wr(8, 32'h0000_FFFF);
    kw[0] ^= 32'h0000_FFFF;
    push("R6", S_KEY, ekey(2));
    next();
    wr(8, 32'h0000_FFFF);
    kw[0] ^= 32'h0000_FFFF;
    push("R6", S_KEY, ekey(2));
    next();

    // R2 enable, R3 lock, R7 key lock
    wr(0, 32'hC76);
    push("R2", S_EN, 1); push("R12", S_RD, 32'hC76);
    next();
    wr(0, 32'h002);
    push("R3", S_ENC, 1); push("R3", S_KS, 2); push("R3", S_MODE, 3);
    push("R3", S_SEG, 4); push("R2", S_EN, 1); push("R3", S_RD, 32'hC76);
    next();
    wr(9, 32'hFFFF_FFFF);
    push("R7", S_KEY, ekey(2));
    next();
    wr(0, 32'h000);
    push("R2", S_EN, 0); push("R3", S_RD, 32'hC74);
    next();
    rd(5);
    push("R12", S_RD, '0);
    next();

    // R11 new-message pulse
    wr(1, 32'h1);
    push("R11", S_NM, 1); push("R11", S_RD, '0);
    next();
    push("R11", S_NM, 0);
    next();

    // R9 software reset, R10 write during reset cycle ignored
    wr(0, 32'h1);
    push("R9", S_RD, 32'hC75); push("R9", S_EN, 0); push("R9", S_KEY, ekey(2));
    next();
    wr(10, 32'h1234_5678);
    for (int i = 0; i < NKW; i++) kw[i] = '0;
    push("R10", S_KEY, '0); push("R9", S_ENC, 0); push("R9", S_KS, 0);
    next();
    rd(0);
    push("R9", S_RD, '0); push("R10", S_EN, 0);
    next();
    wr(8, 32'h5);
    kw[0] = 32'h5;
    push("R5", S_KEY, ekey(0));
    next();

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule